// File: doc/BRIEF.md
# Vector Register Element-Width Tracker

The tracker keeps, for each architectural vector register, a 2-bit tag that records the element width the register was last written with. When an instruction that writes vector registers issues, the tag of every register it writes is updated in one cycle. A segment load with several fields and an instruction with a register group larger than one both write a run of registers starting at the destination, and the issuing logic passes the length of that run as a count.

Each source operand of an issuing instruction is looked up in the table. The tracker compares the stored width with the width the instruction expects to read. When they differ it raises a reshuffle request for that source and returns the stored width, so that a downstream datapath can repack the data. The widening-by-eight extend instructions always read their source as 8-bit elements, whatever the issuing logic supplies as the expected width. When the downstream datapath finishes a repack, it reports the register and its new width through a fix-up port, and the tag is rewritten.

The tracker has no state machine. Its only state is the tag table and one output register per source port.

Top module: `ewidth_tracker`

## Requirements
- R1: After reset every register is tagged 8-bit (code 0). A read that expects 8-bit then raises no request, and old_eew is 0.
- R2: A write with count N tags registers wr_vd through wr_vd+N-1 with wr_eew. For example, a 4-field 16-bit segment load into v8 tags v8, v9, v10 and v11 with 16-bit.
- R3: Registers outside the written run keep their tags.
- R4: Indices do not wrap. A run that would pass v31 tags only up to v31, and low registers are not touched.
- R5: A write with count 0 changes no tag.
- R6: For a valid read, one cycle later old_eew holds the stored tag, and reshuf_req is 1 exactly when that tag differs from the expected width. Width codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit.
- R7: When rd_force8 is set, the expected width is 8-bit (code 0) and rd_eew is ignored.
- R8: A fix-up (fix_valid with fix_vs and fix_eew) retags fix_vs with fix_eew. A later read that expects fix_eew then raises no request.
- R9: A read compares against the table as it was before the edge on which it is captured, so a write presented in the same cycle is not seen. When a write and a fix-up hit the same register in the same cycle, the write's width is stored.
- R10: One cycle after a cycle in which a port has no valid read, that port shows reshuf_req = 0 and old_eew = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A register-writing instruction issues |
| wr_vd | input | IDXW | First destination register |
| wr_cnt | input | CNTW | Number of registers written (fields or group size) |
| wr_eew | input | 2 | Width code written |
| fix_valid | input | 1 | A reshuffle has completed |
| fix_vs | input | IDXW | Register that was reshuffled |
| fix_eew | input | 2 | Width code after the reshuffle |
| rd_valid | input | NSRC | Per-source read valid |
| rd_vs | input | NSRC x IDXW | Per-source register index |
| rd_eew | input | NSRC x 2 | Per-source expected width code |
| rd_force8 | input | NSRC | Per-source force of the 8-bit view |
| reshuf_req | output | NSRC | Per-source reshuffle request |
| old_eew | output | NSRC x 2 | Per-source stored width code |

## Verification
Both read results, reshuf_req and old_eew, come from one register stage, so they are due at the first rising edge after the read is presented. A tag write takes effect at that same edge and is therefore first visible to a read presented one cycle later. The driver applies inputs on the falling edge and pushes the expected result for each source into a queue. The monitor pops the queue 1 ns after the next rising edge, and it checks every port that had no queued item for the quiet values.

// File: rtl/ewt_pkg.sv
package ewt_pkg;
    typedef enum logic [1:0] {
        EW_B8  = 2'd0,
        EW_B16 = 2'd1,
        EW_B32 = 2'd2,
        EW_B64 = 2'd3
    } ew_code_e;
endpackage

// File: rtl/ewt_range_dec.sv
module ewt_range_dec #(
    parameter int NREG = 32,
    parameter int IDXW = 5,
    parameter int CNTW = 4
) (
    input  logic            wr_valid,
    input  logic [IDXW-1:0] wr_vd,
    input  logic [CNTW-1:0] wr_cnt,
    output logic [NREG-1:0] hit
);
    localparam int SUMW = ((IDXW > CNTW) ? IDXW : CNTW) + 1;

    logic [SUMW-1:0] run_lo;
    logic [SUMW-1:0] run_hi;

    assign run_lo = SUMW'(wr_vd);
    assign run_hi = run_lo + SUMW'(wr_cnt);

    // registers past the last index do not exist, so a long run simply stops
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_hit
            localparam logic [SUMW-1:0] SLOT = SUMW'(g);
            assign hit[g] = wr_valid && (SLOT >= run_lo) && (SLOT < run_hi);
        end
    endgenerate
endmodule

// File: rtl/ewt_tag_file.sv
module ewt_tag_file
    import ewt_pkg::*;
#(
    parameter int NREG = 32,
    parameter int IDXW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREG-1:0]      wr_hit,
    input  logic [1:0]           wr_eew,
    input  logic                 fix_valid,
    input  logic [IDXW-1:0]      fix_vs,
    input  logic [1:0]           fix_eew,
    output logic [NREG-1:0][1:0] tags
);
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_tag
            logic fix_here;
            assign fix_here = fix_valid && (fix_vs == IDXW'(g));

            // an issuing write is younger than a finishing reshuffle: it wins
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tags[g] <= EW_B8;
                end else if (wr_hit[g]) begin
                    tags[g] <= wr_eew;
                end else if (fix_here) begin
                    tags[g] <= fix_eew;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ewt_read_port.sv
module ewt_read_port
    import ewt_pkg::*;
#(
    parameter int NREG = 32,
    parameter int IDXW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREG-1:0][1:0] tags,
    input  logic                 rd_valid,
    input  logic [IDXW-1:0]      rd_vs,
    input  logic [1:0]           rd_eew,
    input  logic                 rd_force8,
    output logic                 reshuf_req,
    output logic [1:0]           old_eew
);
    logic [1:0] stored;
    logic [1:0] wanted;

    always_comb begin
        stored = tags[rd_vs];
        wanted = rd_force8 ? EW_B8 : rd_eew;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reshuf_req <= 1'b0;
            old_eew    <= EW_B8;
        end else if (rd_valid) begin
            reshuf_req <= (stored != wanted);
            old_eew    <= stored;
        end else begin
            reshuf_req <= 1'b0;
            old_eew    <= EW_B8;
        end
    end
endmodule

// File: rtl/ewidth_tracker.sv
module ewidth_tracker #(
    parameter int NREG   = 32,
    parameter int MAXCNT = 8,
    parameter int NSRC   = 2,
    localparam int IDXW  = $clog2(NREG),
    localparam int CNTW  = $clog2(MAXCNT + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  logic [IDXW-1:0]           wr_vd,
    input  logic [CNTW-1:0]           wr_cnt,
    input  logic [1:0]                wr_eew,
    input  logic                      fix_valid,
    input  logic [IDXW-1:0]           fix_vs,
    input  logic [1:0]                fix_eew,
    input  logic [NSRC-1:0]           rd_valid,
    input  logic [NSRC-1:0][IDXW-1:0] rd_vs,
    input  logic [NSRC-1:0][1:0]      rd_eew,
    input  logic [NSRC-1:0]           rd_force8,
    output logic [NSRC-1:0]           reshuf_req,
    output logic [NSRC-1:0][1:0]      old_eew
);
    logic [NREG-1:0]      run_hit;
    logic [NREG-1:0][1:0] tag_q;

    ewt_range_dec #(.NREG(NREG), .IDXW(IDXW), .CNTW(CNTW)) u_range (
        .wr_valid (wr_valid),
        .wr_vd    (wr_vd),
        .wr_cnt   (wr_cnt),
        .hit      (run_hit)
    );

    ewt_tag_file #(.NREG(NREG), .IDXW(IDXW)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (run_hit),
        .wr_eew    (wr_eew),
        .fix_valid (fix_valid),
        .fix_vs    (fix_vs),
        .fix_eew   (fix_eew),
        .tags      (tag_q)
    );

    generate
        for (genvar p = 0; p < NSRC; p++) begin : g_src
            ewt_read_port #(.NREG(NREG), .IDXW(IDXW)) u_port (
                .clk        (clk),
                .rst_n      (rst_n),
                .tags       (tag_q),
                .rd_valid   (rd_valid[p]),
                .rd_vs      (rd_vs[p]),
                .rd_eew     (rd_eew[p]),
                .rd_force8  (rd_force8[p]),
                .reshuf_req (reshuf_req[p]),
                .old_eew    (old_eew[p])
            );
        end
    endgenerate
endmodule

// File: rtl/ewidth_tracker_chk.sv
module ewidth_tracker_chk #(
    parameter int NREG   = 32,
    parameter int MAXCNT = 8,
    parameter int NSRC   = 2,
    localparam int IDXW  = $clog2(NREG),
    localparam int CNTW  = $clog2(MAXCNT + 1)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_valid,
    input logic [IDXW-1:0]           wr_vd,
    input logic [CNTW-1:0]           wr_cnt,
    input logic [1:0]                wr_eew,
    input logic [NSRC-1:0]           rd_valid,
    input logic [NSRC-1:0][IDXW-1:0] rd_vs,
    input logic [NSRC-1:0][1:0]      rd_eew,
    input logic [NSRC-1:0]           rd_force8,
    input logic [NSRC-1:0]           reshuf_req,
    input logic [NSRC-1:0][1:0]      old_eew
);
    generate
        for (genvar p = 0; p < NSRC; p++) begin : g_chk
            // R10
            idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_valid[p] |=> (!reshuf_req[p] && old_eew[p] == 2'd0));

            // R7
            force_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_valid[p] && rd_force8[p]) |=> (reshuf_req[p] == (old_eew[p] != 2'd0)));

            // R6
            mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_valid[p] && !rd_force8[p]) |=> (reshuf_req[p] == (old_eew[p] != $past(rd_eew[p]))));

            // R2
            write_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_valid && wr_cnt != '0) ##1 (rd_valid[p] && rd_vs[p] == $past(wr_vd))
                |=> (old_eew[p] == $past(wr_eew, 2)));
        end
    endgenerate
endmodule

bind ewidth_tracker ewidth_tracker_chk #(.NREG(NREG), .MAXCNT(MAXCNT), .NSRC(NSRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_vd      (wr_vd),
    .wr_cnt     (wr_cnt),
    .wr_eew     (wr_eew),
    .rd_valid   (rd_valid),
    .rd_vs      (rd_vs),
    .rd_eew     (rd_eew),
    .rd_force8  (rd_force8),
    .reshuf_req (reshuf_req),
    .old_eew    (old_eew)
);

// File: tb/ewidth_tracker_tb.sv
`timescale 1ns/1ps
module ewidth_tracker_tb;
    localparam int NREG = 32;
    localparam int NSRC = 2;
    localparam int IDXW = 5;
    localparam int CNTW = 4;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      wr_valid = 1'b0;
    logic [IDXW-1:0]           wr_vd = '0;
    logic [CNTW-1:0]           wr_cnt = '0;
    logic [1:0]                wr_eew = '0;
    logic                      fix_valid = 1'b0;
    logic [IDXW-1:0]           fix_vs = '0;
    logic [1:0]                fix_eew = '0;
    logic [NSRC-1:0]           rd_valid = '0;
    logic [NSRC-1:0][IDXW-1:0] rd_vs = '0;
    logic [NSRC-1:0][1:0]      rd_eew = '0;
    logic [NSRC-1:0]           rd_force8 = '0;
    logic [NSRC-1:0]           reshuf_req;
    logic [NSRC-1:0][1:0]      old_eew;

    int checks = 0;
    int fails = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;
    int model [NREG];

    int    q_port [$];
    bit    q_req  [$];
    int    q_old  [$];
    string q_tag  [$];

    always #2 clk = ~clk;

    ewidth_tracker #(.NREG(NREG), .MAXCNT(8), .NSRC(NSRC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_vd(wr_vd), .wr_cnt(wr_cnt), .wr_eew(wr_eew),
        .fix_valid(fix_valid), .fix_vs(fix_vs), .fix_eew(fix_eew),
        .rd_valid(rd_valid), .rd_vs(rd_vs), .rd_eew(rd_eew), .rd_force8(rd_force8),
        .reshuf_req(reshuf_req), .old_eew(old_eew)
    );

    // one cycle of stimulus; expected results are queued for the next edge
    task automatic step(input bit wv, input int vd, input int cnt, input int we,
                        input bit fv, input int fvs, input int fe,
                        input bit r0v, input int r0s, input int r0e, input bit r0f,
                        input bit r1v, input int r1s, input int r1e, input bit r1f,
                        input string tg);
        bit rv [2];
        int rs [2];
        int re [2];
        bit rf [2];
        @(negedge clk);
        rv[0] = r0v; rs[0] = r0s; re[0] = r0e; rf[0] = r0f;
        rv[1] = r1v; rs[1] = r1s; re[1] = r1e; rf[1] = r1f;
        wr_valid  = wv;
        wr_vd     = IDXW'(vd);
        wr_cnt    = CNTW'(cnt);
        wr_eew    = 2'(we);
        fix_valid = fv;
        fix_vs    = IDXW'(fvs);
        fix_eew   = 2'(fe);
        for (int p = 0; p < NSRC; p++) begin
            rd_valid[p]  = rv[p];
            rd_vs[p]     = IDXW'(rs[p]);
            rd_eew[p]    = 2'(re[p]);
            rd_force8[p] = rf[p];
            if (rv[p]) begin
                int want;
                want = rf[p] ? 0 : re[p];
                q_port.push_back(p);
                q_req.push_back(model[rs[p]] != want);
                q_old.push_back(model[rs[p]]);
                q_tag.push_back(tg);
            end
        end
        if (fv) model[fvs] = fe;
        if (wv) begin
            for (int k = 0; k < cnt; k++) begin
                if (vd + k < NREG) model[vd + k] = we;
            end
        end
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
    endtask

    // monitor: compare 1 ns after each rising edge
    always @(posedge clk) begin
        if (mon_on) begin
            bit seen [2];
            #1;
            seen[0] = 1'b0;
            seen[1] = 1'b0;
            while (q_port.size() > 0) begin
                int    p;
                bit    er;
                int    eo;
                string t;
                p  = q_port.pop_front();
                er = q_req.pop_front();
                eo = q_old.pop_front();
                t  = q_tag.pop_front();
                seen[p] = 1'b1;
                checks++;
                if (reshuf_req[p] !== er || int'(old_eew[p]) != eo) begin
                    fails++;
                    $display("FAIL %s port%0d: actual req=%0b old=%0d expected req=%0b old=%0d",
                             t, p, reshuf_req[p], old_eew[p], er, eo);
                end
            end
            for (int p = 0; p < NSRC; p++) begin
                if (!seen[p]) begin
                    checks++;
                    if (reshuf_req[p] !== 1'b0 || old_eew[p] !== 2'd0) begin
                        fails++;
                        $display("FAIL R10 port%0d quiet: actual req=%0b old=%0d expected req=0 old=0",
                                 p, reshuf_req[p], old_eew[p]);
                    end
                end
            end
        end
    end

    initial begin
        #(4 * 50000);
        if (!finished) begin
            fails++;
            $display("FAIL R6 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NREG; r++) model[r] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: reset tags are 8-bit; R6: a 16-bit expectation mismatches
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 31, 0, 0, "R1 reset tag");
        step(0, 0, 0, 0, 0, 0, 0, 1, 5, 1, 0, 1, 17, 3, 0, "R6 mismatch after reset");

        // R2: 4-field 16-bit segment load into v8
        step(1, 8, 4, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 write");
        step(0, 0, 0, 0, 0, 0, 0, 1, 8, 1, 0, 1, 11, 1, 0, "R2 segment tags");
        step(0, 0, 0, 0, 0, 0, 0, 1, 9, 0, 0, 1, 10, 1, 0, "R2 stale view of v9");
        // R3: neighbours untouched
        step(0, 0, 0, 0, 0, 0, 0, 1, 12, 0, 0, 1, 7, 0, 0, "R3 outside run");

        // R4: run past v31 stops, no wrap to v0
        step(1, 30, 4, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 write");
        step(0, 0, 0, 0, 0, 0, 0, 1, 31, 3, 0, 1, 0, 0, 0, "R4 no wrap");
        step(0, 0, 0, 0, 0, 0, 0, 1, 30, 3, 0, 1, 1, 0, 0, "R4 no wrap low");

        // R5: count 0 leaves v3 alone
        step(1, 3, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 write");
        step(0, 0, 0, 0, 0, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0, "R5 zero count");

        // R7: forced 8-bit view ignores rd_eew
        step(1, 28, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 write");
        step(0, 0, 0, 0, 0, 0, 0, 1, 28, 3, 1, 1, 20, 3, 1, "R7 force view");
        step(0, 0, 0, 0, 0, 0, 0, 1, 28, 1, 1, 0, 0, 0, 0, "R7 force view ignores match");

        // R8: reshuffle completion retags v28 as 8-bit
        step(0, 0, 0, 0, 1, 28, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 fix");
        step(0, 0, 0, 0, 0, 0, 0, 1, 28, 0, 0, 1, 28, 1, 0, "R8 retag");

        // R9: same-cycle read sees the old tag; write beats a fix-up
        step(1, 5, 1, 2, 0, 0, 0, 1, 5, 0, 0, 0, 0, 0, 0, "R9 read before write");
        step(1, 6, 1, 1, 1, 6, 2, 1, 5, 2, 0, 0, 0, 0, 0, "R9 write visible next");
        step(0, 0, 0, 0, 0, 0, 0, 1, 6, 1, 0, 1, 6, 2, 0, "R9 write wins over fix");

        idle();

        // R6: mixed random traffic against the bench model
        for (int i = 0; i < 400; i++) begin
            int c;
            c = int'($urandom_range(0, 8));
            step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)), c, int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)), int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)), int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 3) == 0),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)), int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 3) == 0),
                 "R6 random");
        end

        idle();
        idle();
        @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule